// File: doc/BRIEF.md
# DDR Refresh Request Scheduler

This block decides when a DDR SDRAM controller owes the memory an auto-refresh. A free-running interval timer counts controller clocks. Each time it expires, one more refresh becomes due. Due refreshes pile up in a saturating backlog counter of at most eight entries. This lets the command arbiter postpone refreshes while traffic is heavy, and then pay them back in a burst.

The scheduler raises a request whenever at least one refresh is owed, every bank is precharged and the refresh row cycle time from the previous refresh has elapsed. The arbiter answers each refresh it issues with a one-cycle acknowledge. When the backlog comes close to the limit, an urgent flag tells the arbiter to close all rows and refresh at once. While the device refreshes itself, the backlog is emptied and the timer is held. When self refresh ends, counting restarts from a full interval.

The interval defaults to floor(7800 ns / tCK) clocks, which is 1040 at 7.5 ns. The hold-off defaults to ceil(75 ns / tCK) clocks.

Top module: `refresh_sched`

## Requirements
- R1: After reset, the owed count is 0 and both the request and the urgent flag are low.
- R2: Outside self refresh, the owed count rises by one every INTERVAL_CLKS clocks. The first rise comes INTERVAL_CLKS clocks after reset or after self refresh ends.
- R3: The owed count saturates at MAX_OWED (8). An interval expiry while the count is at 8 leaves it at 8.
- R4: An acknowledge taken while the count is non-zero lowers the count by one on the next clock.
- R5: An acknowledge while the count is 0 leaves the count at 0.
- R6: The urgent flag is high exactly when the owed count is URGENT_LEVEL (7) or more, whatever the state of the banks.
- R7: The request is high only while the count is non-zero and the bank-idle input is high. It follows that input in the same cycle.
- R8: After an acknowledge, the request stays low for TRFC_CLKS clocks. It may rise again on the clock after that.
- R9: While self refresh is active, the count is forced to 0, the request is low, and acknowledges are ignored.
- R10: An interval expiry and an acknowledge in the same clock leave the count unchanged. At 8 the count also stays at 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| banks_idle_i | input | 1 | High when every bank is precharged |
| ref_ack_i | input | 1 | One-cycle pulse: an auto-refresh was issued |
| self_ref_i | input | 1 | High while the device is in self refresh |
| ref_req_o | output | 1 | Refresh request to the command arbiter |
| ref_urgent_o | output | 1 | Backlog is near its limit |
| owed_o | output | OWED_W | Number of refreshes currently owed |

## Verification
The hardest situation to reach is an interval expiry that falls in the same clock as an acknowledge, with or without a saturated backlog. Reaching it from the ports takes exact alignment against the hidden timer phase. The bench therefore restarts the timer through self refresh and sweeps the acknowledge offset over every phase of a short interval, crossed with bank-idle patterns. A cycle-accurate arithmetic model of the requirements predicts each output on every cycle.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
  localparam int unsigned REFI_PS = 7_800_000;
  localparam int unsigned TRFC_PS = 75_000;

  function automatic int unsigned interval_from_period(input int unsigned tck_ps);
    return REFI_PS / tck_ps;
  endfunction

  function automatic int unsigned trfc_from_period(input int unsigned tck_ps);
    return (TRFC_PS + tck_ps - 1) / tck_ps;
  endfunction
endpackage

// File: rtl/refsch_interval_timer.sv
module refsch_interval_timer #(
  parameter int unsigned INTERVAL_CLKS = 1040,
  localparam int unsigned CNT_W = (INTERVAL_CLKS > 1) ? $clog2(INTERVAL_CLKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(INTERVAL_CLKS - 1));
  assign tick_o = at_end && !hold_i;
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i)      cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/refsch_owed_ctr.sv
module refsch_owed_ctr #(
  parameter int unsigned MAX_OWED = 8,
  localparam int unsigned OWED_W = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [OWED_W-1:0] owed_o
);
  logic [OWED_W:0]   sum;
  logic [OWED_W-1:0] owed_q, owed_d;
  logic              take_dec;
  logic              upd_en;

  assign take_dec = dec_i && (owed_q != '0);
  assign upd_en   = clr_i || inc_i || take_dec;

  always_comb begin
    sum = {1'b0, owed_q} + {{OWED_W{1'b0}}, inc_i} - {{OWED_W{1'b0}}, take_dec};
    if (clr_i)                           owed_d = '0;
    else if (sum > (OWED_W+1)'(MAX_OWED)) owed_d = OWED_W'(MAX_OWED);
    else                                  owed_d = sum[OWED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      owed_q <= '0;
    else if (upd_en) owed_q <= owed_d;
  end

  assign owed_o = owed_q;
endmodule

// File: rtl/refsch_holdoff.sv
module refsch_holdoff #(
  parameter int unsigned TRFC_CLKS = 10,
  localparam int unsigned HOLD_W = $clog2(TRFC_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              hold_en;

  assign busy_o  = (hold_q != '0);
  assign hold_en = start_i || busy_o;

  always_comb begin
    if (start_i) hold_d = HOLD_W'(TRFC_CLKS);
    else         hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned TCK_PS        = 7500,
  parameter int unsigned INTERVAL_CLKS = refsch_pkg::interval_from_period(TCK_PS),
  parameter int unsigned TRFC_CLKS     = refsch_pkg::trfc_from_period(TCK_PS),
  parameter int unsigned MAX_OWED      = 8,
  parameter int unsigned URGENT_LEVEL  = 7,
  localparam int unsigned OWED_W       = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              banks_idle_i,
  input  logic              ref_ack_i,
  input  logic              self_ref_i,
  output logic              ref_req_o,
  output logic              ref_urgent_o,
  output logic [OWED_W-1:0] owed_o
);
  logic rst_meta_q, rst_sync_q;
  logic tick;
  logic ack_ok;
  logic trfc_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign ack_ok = ref_ack_i && !self_ref_i;

  refsch_interval_timer #(.INTERVAL_CLKS(INTERVAL_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .hold_i (self_ref_i),
    .tick_o (tick)
  );

  refsch_owed_ctr #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .clr_i  (self_ref_i),
    .inc_i  (tick),
    .dec_i  (ack_ok),
    .owed_o (owed_o)
  );

  refsch_holdoff #(.TRFC_CLKS(TRFC_CLKS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start_i (ack_ok),
    .busy_o  (trfc_busy)
  );

  assign ref_req_o    = (owed_o != '0) && banks_idle_i && !trfc_busy && !self_ref_i;
  assign ref_urgent_o = (owed_o >= OWED_W'(URGENT_LEVEL));
endmodule

// File: rtl/refsch_checks.sv
module refsch_checks #(
  parameter int unsigned MAX_OWED     = 8,
  parameter int unsigned URGENT_LEVEL = 7,
  parameter int unsigned OWED_W       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              banks_idle_i,
  input logic              ref_ack_i,
  input logic              self_ref_i,
  input logic              ref_req_o,
  input logic              ref_urgent_o,
  input logic [OWED_W-1:0] owed_o
);
  assert_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    owed_o <= OWED_W'(MAX_OWED));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(self_ref_i) |-> ((owed_o <= $past(owed_o) + 1'b1) && (owed_o + 1'b1 >= $past(owed_o))));

  assert_urgent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_o >= OWED_W'(URGENT_LEVEL)) |-> ref_urgent_o);

  assert_idle_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req_o |-> (banks_idle_i && owed_o != '0));

  assert_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ref_ack_i && !self_ref_i) |-> !ref_req_o);

  assert_selfref_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(self_ref_i) |-> (owed_o == '0));
endmodule

bind refresh_sched refsch_checks #(
  .MAX_OWED(MAX_OWED), .URGENT_LEVEL(URGENT_LEVEL), .OWED_W(OWED_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .banks_idle_i(banks_idle_i), .ref_ack_i(ref_ack_i),
  .self_ref_i(self_ref_i), .ref_req_o(ref_req_o), .ref_urgent_o(ref_urgent_o),
  .owed_o(owed_o)
);

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
  localparam int IV   = 5;
  localparam int TRFC = 3;
  localparam int MAXO = 8;
  localparam int URG  = 7;
  localparam int OW   = $clog2(MAXO + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle = 1'b0, ack = 1'b0, sr = 1'b0;
  logic req, urgent;
  logic [OW-1:0] owed;

  int n_chk = 0, n_bad = 0;
  int m_cnt = 0, m_owed = 0, m_hold = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  refresh_sched #(.INTERVAL_CLKS(IV), .TRFC_CLKS(TRFC), .MAX_OWED(MAXO),
                  .URGENT_LEVEL(URG)) dut (
    .clk(clk), .rst_n(rst_n), .banks_idle_i(idle), .ref_ack_i(ack),
    .self_ref_i(sr), .ref_req_o(req), .ref_urgent_o(urgent), .owed_o(owed));

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int e_req;
    e_req = (m_owed > 0 && idle && m_hold == 0 && !sr) ? 1 : 0;
    check("owed", int'(owed), m_owed);
    check("req", int'(req), e_req);
    check("urgent", int'(urgent), (m_owed >= URG) ? 1 : 0);
  endtask

  // drive at negedge, model updates at posedge, compare at next negedge
  task automatic cyc(input logic i_idle, input logic i_ack, input logic i_sr);
    int tick, dec, nxt;
    idle = i_idle; ack = i_ack; sr = i_sr;
    @(posedge clk);
    tick = (!i_sr && m_cnt == IV - 1) ? 1 : 0;
    dec  = (i_ack && !i_sr && m_owed > 0) ? 1 : 0;
    m_cnt = (i_sr || tick != 0) ? 0 : m_cnt + 1;
    nxt = m_owed + tick - dec;
    m_owed = i_sr ? 0 : ((nxt > MAXO) ? MAXO : nxt);
    if (i_ack && !i_sr) m_hold = TRFC;
    else if (m_hold > 0) m_hold = m_hold - 1;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    tag = "R1"; compare();

    // R2: accumulate with banks busy so nothing is drained
    tag = "R2";
    for (int c = 0; c < 3 * IV; c++) cyc(1'b0, 1'b0, 1'b0);
    check("owed after 3 intervals", int'(owed), 3);

    // R6 then R3: grow past the limit
    tag = "R6";
    for (int c = 0; c < 4 * IV; c++) cyc(c[0], 1'b0, 1'b0);
    tag = "R3";
    for (int c = 0; c < 3 * IV; c++) cyc(1'b1, 1'b0, 1'b0);
    check("saturated owed", int'(owed), MAXO);

    // R7: bank-idle gating while owed
    tag = "R7";
    for (int c = 0; c < 8; c++) cyc(c[1], 1'b0, 1'b0);

    // R4 and R8: drain with acknowledges, spaced over the hold-off
    for (int k = 0; k < 12; k++) begin
      tag = "R4"; cyc(1'b1, req, 1'b0);
      tag = "R8";
      for (int w = 0; w < TRFC + 1; w++) cyc(1'b1, 1'b0, 1'b0);
    end

    // R5: acknowledges at zero owed
    tag = "R9";
    cyc(1'b1, 1'b0, 1'b1);
    tag = "R5";
    for (int c = 0; c < IV - 1; c++) cyc(1'b1, 1'b1, 1'b0);
    check("owed zero after acks", int'(owed), 0);

    // R9: self refresh in the middle of a backlog, with acks ignored
    tag = "R9";
    for (int c = 0; c < 2 * IV + 2; c++) cyc(1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 4; c++) cyc(1'b1, 1'b1, 1'b1);
    check("owed in self refresh", int'(owed), 0);
    for (int c = 0; c < IV; c++) cyc(1'b1, 1'b0, 1'b0);
    check("first expiry after exit", int'(owed), 1);

    // R10: sweep acknowledge phase against expiry, crossed with idle patterns
    tag = "R10";
    for (int off = 0; off < IV; off++) begin
      for (int pat = 0; pat < 4; pat++) begin
        cyc(1'b0, 1'b0, 1'b1);
        for (int c = 0; c < (pat == 3 ? 10 : 3) * IV; c++)
          cyc(pat[0] | c[0], (c % IV) == off && pat != 3 ? 1'b1 : 1'b0, 1'b0);
        for (int c = 0; c < 2 * IV; c++)
          cyc(pat[1], (c % IV) == off ? 1'b1 : 1'b0, 1'b0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule